// File: doc/BRIEF.md
# Four-Shape Countdown Timer

This block is a single down-counting timer. It runs on its clock input. A terminal count and a two-bit shape mode are loaded through a synchronous write port. A start command begins a run using the values held at that moment. A stop command ends the run at once.

The output pin idles high. Two modes give square waves: one gives a single cycle, the other repeats. When the terminal count is odd, the high half is one clock longer than the low half. The other two modes give active-low pulses one clock wide, either a single pulse or a repeating train. A busy flag shows that a run is in progress.

A typical use loads the count and the mode once. The controlling logic then pulses start and waits on busy for a one-shot result, or lets a continuous mode run as a divided clock or a periodic strobe until it issues stop.

Top module: `quad_wave_timer`

## Requirements
- R1: After reset, `wave_out` is 1 and `busy` is 0.
- R2: With mode 2'b00 and terminal count TC, a start gives exactly one square cycle. The output is high for the first ceil(TC/2) clocks, beginning with the clock after the start edge, and low for the next floor(TC/2) clocks. After that it returns high and stays high.
- R3: With mode 2'b01 the square cycle of R2 repeats without gaps, with period TC, until stop.
- R4: The two halves of a square cycle add up to TC. For even TC they are equal. For odd TC the high half is (TC+1)/2 and the low half is (TC-1)/2.
- R5: With mode 2'b10, a start gives one low pulse, one clock wide, in the TC-th clock after the start edge. The output is high before and after that pulse.
- R6: With mode 2'b11, the low pulse of R5 repeats every TC clocks until stop.
- R7: A terminal count of 0 or 1 behaves exactly like a terminal count of 2.
- R8: A stop forces `wave_out` high and `busy` low from the next clock, and both stay so until the next start. The next start runs the held configuration from its beginning.
- R9: A start during a run abandons that run and restarts from the beginning of the held configuration.
- R10: A configuration write during a run does not change that run. The new count and mode take effect at the next start.
- R11: `busy` rises on the clock after a start. In one-shot modes it falls exactly TC clocks after the start edge. In continuous modes it stays high until a stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock; every rising edge is one count |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Loads `cfg_count` and `cfg_mode` on this edge |
| cfg_count | input | CNT_W | Terminal count TC |
| cfg_mode | input | 2 | Shape: 00 square once, 01 square loop, 10 pulse once, 11 pulse loop |
| start | input | 1 | Begin or restart a run |
| stop | input | 1 | End the run; takes precedence over start |
| wave_out | output | 1 | Shaped output, idle high |
| busy | output | 1 | High while a run is in progress |

## Verification
Two situations are hard to reach from the ports. The first is a configuration write that lands in the middle of a continuous run. The second is a restart issued partway through a half. In both, the design must keep working from the snapshot it took at start, not from the live registers. The stimulus starts a repeating pulse train and writes a different count and mode two clocks later. It checks that the train keeps its old period, and only then issues a new start and checks the new one-shot shape. Odd counts, counts below two, and stop followed by restart are covered by separate directed runs. Each run compares every clock against an expected waveform built from the count and mode.

// File: rtl/qwt_pkg.sv
package qwt_pkg;

    localparam int unsigned QWT_CNT_W = 16;

    typedef enum logic [1:0] {
        MODE_SQ_ONCE    = 2'b00,
        MODE_SQ_LOOP    = 2'b01,
        MODE_PULSE_ONCE = 2'b10,
        MODE_PULSE_LOOP = 2'b11
    } shape_mode_e;

    typedef enum logic {
        PH_HIGH = 1'b0,
        PH_LOW  = 1'b1
    } phase_e;

    function automatic logic mode_is_pulse(shape_mode_e m);
        return m[1];
    endfunction

    function automatic logic mode_is_loop(shape_mode_e m);
        return m[0];
    endfunction

endpackage

// File: rtl/qwt_cfg_regs.sv
module qwt_cfg_regs
    import qwt_pkg::*;
#(
    parameter int unsigned CNT_W = QWT_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CNT_W-1:0] count_in,
    input  logic [1:0]       mode_in,
    output logic [CNT_W-1:0] tc_q,
    output shape_mode_e      mode_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            tc_q   <= '0;
            mode_q <= MODE_SQ_ONCE;
        end else if (we) begin
            tc_q   <= count_in;
            mode_q <= shape_mode_e'(mode_in);
        end
    end

endmodule

// File: rtl/qwt_shape.sv
module qwt_shape
    import qwt_pkg::*;
#(
    parameter int unsigned CNT_W = QWT_CNT_W
) (
    input  logic [CNT_W-1:0] tc,
    input  shape_mode_e      mode,
    output logic [CNT_W-1:0] tc_eff,
    output logic [CNT_W-1:0] hi_len,
    output logic [CNT_W-1:0] lo_len
);

    localparam logic [CNT_W-1:0] MIN_TC = CNT_W'(2);
    localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);

    always_comb begin
        tc_eff = (tc < MIN_TC) ? MIN_TC : tc;
        if (mode_is_pulse(mode)) begin
            // pulse: high for TC-1 clocks, then one low clock
            hi_len = tc_eff - ONE;
            lo_len = ONE;
        end else begin
            // square: the odd clock goes to the high half
            hi_len = (tc_eff >> 1) + {{(CNT_W-1){1'b0}}, tc_eff[0]};
            lo_len = tc_eff >> 1;
        end
    end

endmodule

// File: rtl/qwt_seq.sv
module qwt_seq
    import qwt_pkg::*;
#(
    parameter int unsigned CNT_W = QWT_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             stop,
    input  shape_mode_e      mode,
    input  logic [CNT_W-1:0] hi_len,
    input  logic [CNT_W-1:0] lo_len,
    output logic             wave_out,
    output logic             busy
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic             running;
    phase_e           phase;
    logic [CNT_W-1:0] cnt;
    shape_mode_e      run_mode;
    logic [CNT_W-1:0] run_hi;
    logic [CNT_W-1:0] run_lo;

    always_ff @(posedge clk) begin
        if (rst) begin
            running  <= 1'b0;
            phase    <= PH_HIGH;
            cnt      <= '0;
            run_mode <= MODE_SQ_ONCE;
            run_hi   <= '0;
            run_lo   <= '0;
        end else if (stop) begin
            running <= 1'b0;
            phase   <= PH_HIGH;
        end else if (start) begin
            running  <= 1'b1;
            phase    <= PH_HIGH;
            cnt      <= hi_len;
            run_mode <= mode;
            run_hi   <= hi_len;
            run_lo   <= lo_len;
        end else if (running) begin
            if (cnt == ONE) begin
                if (phase == PH_HIGH) begin
                    phase <= PH_LOW;
                    cnt   <= run_lo;
                end else if (mode_is_loop(run_mode)) begin
                    phase <= PH_HIGH;
                    cnt   <= run_hi;
                end else begin
                    running <= 1'b0;
                    phase   <= PH_HIGH;
                end
            end else begin
                cnt <= cnt - ONE;
            end
        end
    end

    assign wave_out = !(running && (phase == PH_LOW));
    assign busy     = running;

    AST_RUN_CNT_NONZERO: assert property (@(posedge clk) disable iff (rst)
        running |-> (cnt != '0));  // R3

    AST_STOP_IDLES: assert property (@(posedge clk) disable iff (rst)
        stop |=> (!busy && wave_out));  // R8

    AST_START_HIGH: assert property (@(posedge clk) disable iff (rst)
        (start && !stop) |=> (busy && wave_out));  // R9

    AST_PULSE_ONE_CLK: assert property (@(posedge clk) disable iff (rst)
        (running && mode_is_pulse(run_mode) && !wave_out && !stop && !start)
            |=> wave_out);  // R5

    AST_ONESHOT_ENDS: assert property (@(posedge clk) disable iff (rst)
        (running && !mode_is_loop(run_mode) && phase == PH_LOW && cnt == ONE
            && !stop && !start) |=> !busy);  // R11

endmodule

// File: rtl/quad_wave_timer.sv
module quad_wave_timer
    import qwt_pkg::*;
#(
    parameter int unsigned CNT_W = QWT_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [CNT_W-1:0] cfg_count,
    input  logic [1:0]       cfg_mode,
    input  logic             start,
    input  logic             stop,
    output logic             wave_out,
    output logic             busy
);

    localparam int unsigned SUM_W = CNT_W + 1;

    logic [CNT_W-1:0] tc_q;
    shape_mode_e      mode_q;
    logic [CNT_W-1:0] tc_eff;
    logic [CNT_W-1:0] hi_len;
    logic [CNT_W-1:0] lo_len;

    qwt_cfg_regs #(.CNT_W(CNT_W)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .we       (cfg_we),
        .count_in (cfg_count),
        .mode_in  (cfg_mode),
        .tc_q     (tc_q),
        .mode_q   (mode_q)
    );

    qwt_shape #(.CNT_W(CNT_W)) u_shape (
        .tc     (tc_q),
        .mode   (mode_q),
        .tc_eff (tc_eff),
        .hi_len (hi_len),
        .lo_len (lo_len)
    );

    qwt_seq #(.CNT_W(CNT_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .stop     (stop),
        .mode     (mode_q),
        .hi_len   (hi_len),
        .lo_len   (lo_len),
        .wave_out (wave_out),
        .busy     (busy)
    );

    AST_SPLIT_SUM: assert property (@(posedge clk) disable iff (rst)
        start |-> ((SUM_W'(hi_len) + SUM_W'(lo_len) == SUM_W'(tc_eff))
                   && hi_len != '0 && lo_len != '0));  // R4

    AST_MIN_COUNT: assert property (@(posedge clk) disable iff (rst)
        start |-> (tc_eff >= CNT_W'(2)));  // R7

endmodule

// File: tb/tb_quad_wave_timer.sv
`timescale 1ns/1ps
module tb_quad_wave_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_count = '0;
    logic [1:0]  cfg_mode = '0;
    logic        start = 1'b0;
    logic        stop = 1'b0;
    logic        wave_out;
    logic        busy;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    quad_wave_timer dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_count(cfg_count),
        .cfg_mode(cfg_mode), .start(start), .stop(stop),
        .wave_out(wave_out), .busy(busy)
    );

    function automatic int eff_tc(int tc);
        return (tc < 2) ? 2 : tc;
    endfunction

    // expected output i clocks after the start edge (i = 0 is the first)
    function automatic int exp_wave(int m, int tc, int i);
        int e = eff_tc(tc);
        int p;
        if ((m % 2) == 0 && i >= e) return 1;
        p = i % e;
        if (m >= 2) return (p == e - 1) ? 0 : 1;
        return (p < (e + 1) / 2) ? 1 : 0;
    endfunction

    function automatic int exp_busy(int m, int tc, int i);
        if ((m % 2) == 1) return 1;
        return (i < eff_tc(tc)) ? 1 : 0;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic write_cfg(input int m, input int tc);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_mode = 2'(m);
        cfg_count = 16'(tc);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_start;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic compare(input int m, input int tc, input int i0, input int n, input string req);
        for (int i = 0; i < n; i++) begin
            chk(wave_out == 1'(exp_wave(m, tc, i0 + i)), req,
                int'(wave_out), exp_wave(m, tc, i0 + i));
            chk(busy == 1'(exp_busy(m, tc, i0 + i)), "R11",
                int'(busy), exp_busy(m, tc, i0 + i));
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        chk(wave_out == 1'b1, "R1", int'(wave_out), 1);
        chk(busy == 1'b0, "R1", int'(busy), 0);
    endtask

    task automatic t_shape(input int m, input int tc, input int n, input string req);
        write_cfg(m, tc);
        do_start();
        compare(m, tc, 0, n, req);
    endtask

    task automatic t_stop;
        write_cfg(1, 6);
        do_start();
        compare(1, 6, 0, 4, "R3");
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        for (int i = 0; i < 8; i++) begin
            chk(wave_out == 1'b1, "R8", int'(wave_out), 1);
            chk(busy == 1'b0, "R8", int'(busy), 0);
            @(negedge clk);
        end
        do_start();
        compare(1, 6, 0, 12, "R8");
    endtask

    task automatic t_restart;
        write_cfg(1, 7);
        do_start();
        compare(1, 7, 0, 5, "R3");
        do_start();
        compare(1, 7, 0, 14, "R9");
    endtask

    task automatic t_cfg_midrun;
        write_cfg(3, 5);
        do_start();
        compare(3, 5, 0, 2, "R6");
        cfg_we = 1'b1;
        cfg_mode = 2'b00;
        cfg_count = 16'd9;
        compare(3, 5, 2, 1, "R10");
        cfg_we = 1'b0;
        compare(3, 5, 3, 12, "R10");
        do_start();
        compare(0, 9, 0, 12, "R10");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_shape(0, 6, 10, "R2");
        t_shape(0, 7, 12, "R4");
        t_shape(1, 8, 24, "R3");
        t_shape(1, 5, 20, "R4");
        t_shape(2, 4, 8, "R5");
        t_shape(2, 1, 5, "R7");
        t_shape(3, 3, 12, "R6");
        t_shape(1, 1, 8, "R7");
        t_shape(3, 0, 8, "R7");
        t_shape(1, 65535, 20, "R4");
        t_stop();
        t_restart();
        t_cfg_midrun();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule